// File: doc/BRIEF.md
# HMAC Accelerator Control and Status Register Bank

This block is the memory-mapped register front end of a SHA-256 / HMAC accelerator. A simple 32-bit peripheral bus reads and writes it. It holds the control, configuration, status, transfer-size, interrupt, initial-hash, key, key-address, key-mask and DMA address registers, and presents every field as a plain output to the hash engine and its helpers.

Two registers are data ports instead of storage. A word written to the message port is pushed to the engine one cycle later, byte-reversed unless the configuration asks otherwise. Each read of the result port returns the next 32-bit word of the 256-bit digest, starting with the most significant word. Status pulses from the engine set status flags, clear self-clearing request bits and raise the completion interrupt.

The bus read path is combinational: `bus_rdata` is valid in the same cycle as a read request. Writes, and the side effects of a read, take effect at the rising clock edge that ends the request cycle.

Top module: `hmac_csr`

## Requirements
- R1: After reset every register, every control output, `msg_push` and `irq` are zero, and reads of all registers return zero.
- R2: The control word at 0x00 has enable in bit 0 and DMA start in bit 1, both readable. Writing 1 to bit 2 sets `key_fetch` and writing 1 to bit 3 sets `last_blk`. Bits 2 and 3 always read as zero.
- R3: `key_fetch` is low in the cycle after `ev_key_valid` pulses, and `last_blk` is low in the cycle after `ev_hmac_ready` pulses. The event wins over a write that sets the bit in the same cycle.
- R4: The configuration word at 0x04 has these fields: bit 0 user initial hash, bit 1 no byte swap, bits 3:2 key source, bit 4 SHA-only, bit 5 private mode. Bits above 5 read as zero.
- R5: The status word at 0x08 has bit 0 hash ready, bit 1 DMA message done, bit 2 DMA error, bit 3 key valid, bit 4 HMAC ready and bit 5 DMA done. Each bit is set by its event input. Bits 2, 4 and 5 are cleared by writing 1, and writes to bits 0, 1 and 3 are ignored. A control write that takes enable from 0 to 1 clears all six bits.
- R6: In the interrupt word at 0x10, bit 0 is the done flag and bit 1 is its enable. `ev_hmac_ready` sets the done flag. Writing 1 to bit 0 clears it and writing 0 leaves it unchanged. A new operation (enable going 0 to 1) also clears it. `irq` is high exactly when both the flag and its enable are set.
- R7: The transfer size at 0x0C keeps 15 bits and ignores the bits above them. `block_count` equals bits 14:6 plus one: 0x003F gives 1, 0x007F gives 2 and 0x7FFF gives 512.
- R8: The eight initial-hash words at 0x20..0x3C are readable. The word at 0x20 drives `user_iv[255:224]` and the word at 0x3C drives `user_iv[31:0]`.
- R9: The eight key words at 0x48..0x64 and the key mask at 0x6C are write-only and read as zero. The word at 0x48 drives `key_val[255:224]`. The key address at 0x68 is readable.
- R10: A write to 0x44 raises `msg_push` for exactly one cycle, starting the cycle after the write. `msg_word` is the written word with its byte order reversed when configuration bit 1 is 0, and unchanged when that bit is 1. Reads of 0x44 return zero.
- R11: While status bit 4 is set, a read of 0x40 returns digest word k, where word 0 is `digest_in[255:224]`, and then advances k, wrapping from 7 to 0. While bit 4 is clear, the read returns zero and k does not advance. A new operation resets k to 0.
- R12: The DMA source address at 0x14 and the DMA destination address at 0x18 are full 32-bit readable registers. Unmapped offsets such as 0x1C read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ev_hash_ready | input | 1 | Engine: hash result ready pulse |
| ev_msg_done | input | 1 | Engine: all message blocks sent pulse |
| ev_dma_err | input | 1 | Engine: DMA error pulse |
| ev_key_valid | input | 1 | Engine: key fetched pulse |
| ev_hmac_ready | input | 1 | Engine: HMAC result ready pulse |
| ev_dma_done | input | 1 | Engine: DMA transfer done pulse |
| digest_in | input | 256 | Digest from the engine |
| run_en | output | 1 | Operation enable |
| dma_go | output | 1 | DMA start |
| key_fetch | output | 1 | Key fetch request |
| last_blk | output | 1 | Last block / last transfer |
| cfg_user_iv | output | 1 | Use user initial hash |
| cfg_no_swap | output | 1 | Disable byte reversal |
| cfg_key_src | output | 2 | Key source select |
| cfg_sha_only | output | 1 | Plain SHA instead of HMAC |
| cfg_private | output | 1 | Side-channel-resistant mode |
| xfer_size | output | 15 | Transfer size register |
| block_count | output | 10 | Number of 64-byte blocks |
| user_iv | output | 256 | User initial hash |
| key_val | output | 256 | Processor-written key |
| key_addr | output | 32 | Key address in memory |
| key_mask | output | 32 | Key port mask |
| dma_src | output | 32 | DMA read start address |
| dma_dst | output | 32 | DMA write start address |
| msg_push | output | 1 | Message word valid, one cycle |
| msg_word | output | 32 | Message word to the engine |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach is a read of the result port that coincides with the ready state appearing and disappearing. Only a correctly timed engine pulse, a status clear and an operation restart together show whether the word index stays put, advances and resets as R11 requires.

The bench therefore first reads the port while HMAC-ready is clear and confirms that the next ready read still returns word 0. It then reads nine words in a row to cross the wrap, and finally restarts the operation partway through a readout to see the index return to 0. Same-cycle collisions between a setting write and a self-clearing event are driven in one cycle to establish which side wins.

// File: rtl/hmac_csr.sv
module hmac_csr #(
  parameter int AW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_en,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic           ev_hash_ready,
  input  logic           ev_msg_done,
  input  logic           ev_dma_err,
  input  logic           ev_key_valid,
  input  logic           ev_hmac_ready,
  input  logic           ev_dma_done,
  input  logic [255:0]   digest_in,
  output logic           run_en,
  output logic           dma_go,
  output logic           key_fetch,
  output logic           last_blk,
  output logic           cfg_user_iv,
  output logic           cfg_no_swap,
  output logic [1:0]     cfg_key_src,
  output logic           cfg_sha_only,
  output logic           cfg_private,
  output logic [14:0]    xfer_size,
  output logic [9:0]     block_count,
  output logic [255:0]   user_iv,
  output logic [255:0]   key_val,
  output logic [31:0]    key_addr,
  output logic [31:0]    key_mask,
  output logic [31:0]    dma_src,
  output logic [31:0]    dma_dst,
  output logic           msg_push,
  output logic [31:0]    msg_word,
  output logic           irq
);

  localparam int NW = 8;
  localparam int SW = 15;
  localparam int BW = SW - 5;
  localparam logic [AW-1:0] A_CTL  = AW'(8'h00);
  localparam logic [AW-1:0] A_CFG  = AW'(8'h04);
  localparam logic [AW-1:0] A_STAT = AW'(8'h08);
  localparam logic [AW-1:0] A_SIZE = AW'(8'h0C);
  localparam logic [AW-1:0] A_INT  = AW'(8'h10);
  localparam logic [AW-1:0] A_SRC  = AW'(8'h14);
  localparam logic [AW-1:0] A_DST  = AW'(8'h18);
  localparam logic [AW-1:0] A_IV   = AW'(8'h20);
  localparam logic [AW-1:0] A_OUT  = AW'(8'h40);
  localparam logic [AW-1:0] A_IN   = AW'(8'h44);
  localparam logic [AW-1:0] A_KEY  = AW'(8'h48);
  localparam logic [AW-1:0] A_KADR = AW'(8'h68);
  localparam logic [AW-1:0] A_KMSK = AW'(8'h6C);
  localparam logic [5:0]    W1C_MASK = 6'b110100;

  logic        wr, rd, start, pop;
  logic        en_q, dma_q, kreq_q, last_q;
  logic [5:0]  cfg_q;
  logic [5:0]  st_q, st_d, ev_vec;
  logic [SW-1:0] size_q;
  logic        done_q, done_d, ien_q;
  logic [31:0] src_q, dst_q, kaddr_q, kmask_q, word_q;
  logic        push_q;
  logic [2:0]  idx_q;
  logic [31:0] iv_q  [NW];
  logic [31:0] key_q [NW];

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  assign wr     = bus_en & bus_we;
  assign rd     = bus_en & ~bus_we;
  assign start  = wr && (bus_addr == A_CTL) && bus_wdata[0] && !en_q;
  assign pop    = rd && (bus_addr == A_OUT) && st_q[4];
  assign ev_vec = {ev_dma_done, ev_hmac_ready, ev_key_valid,
                   ev_dma_err, ev_msg_done, ev_hash_ready};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dma_q  <= 1'b0;
      kreq_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (wr && bus_addr == A_CTL) begin
        en_q  <= bus_wdata[0];
        dma_q <= bus_wdata[1];
        if (bus_wdata[2]) kreq_q <= 1'b1;
        if (bus_wdata[3]) last_q <= 1'b1;
      end
      if (ev_key_valid)  kreq_q <= 1'b0;
      if (ev_hmac_ready) last_q <= 1'b0;
    end
  end

  always_comb begin
    st_d = st_q;
    if (start) st_d = '0;
    if (wr && bus_addr == A_STAT) st_d = st_d & ~(bus_wdata[5:0] & W1C_MASK);
    st_d = st_d | ev_vec;
  end

  always_comb begin
    done_d = done_q;
    if (start) done_d = 1'b0;
    if (wr && bus_addr == A_INT && bus_wdata[0]) done_d = 1'b0;
    if (ev_hmac_ready) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      st_q    <= '0;
      size_q  <= '0;
      done_q  <= 1'b0;
      ien_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      kaddr_q <= '0;
      kmask_q <= '0;
      idx_q   <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (wr) begin
        case (bus_addr)
          A_CFG:  cfg_q   <= bus_wdata[5:0];
          A_SIZE: size_q  <= bus_wdata[SW-1:0];
          A_INT:  ien_q   <= bus_wdata[1];
          A_SRC:  src_q   <= bus_wdata;
          A_DST:  dst_q   <= bus_wdata;
          A_KADR: kaddr_q <= bus_wdata;
          A_KMSK: kmask_q <= bus_wdata;
          default: ;
        endcase
      end
      if (start)    idx_q <= '0;
      else if (pop) idx_q <= idx_q + 3'd1;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_words
    localparam logic [AW-1:0] IV_A  = A_IV  + AW'(4 * g);
    localparam logic [AW-1:0] KEY_A = A_KEY + AW'(4 * g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        iv_q[g]  <= '0;
        key_q[g] <= '0;
      end else if (wr) begin
        if (bus_addr == IV_A)  iv_q[g]  <= bus_wdata;
        if (bus_addr == KEY_A) key_q[g] <= bus_wdata;
      end
    end
    assign user_iv[(NW-1-g)*32 +: 32] = iv_q[g];
    assign key_val[(NW-1-g)*32 +: 32] = key_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_q <= 1'b0;
      word_q <= '0;
    end else begin
      push_q <= wr && (bus_addr == A_IN);
      if (wr && bus_addr == A_IN)
        word_q <= cfg_q[1] ? bus_wdata : swap32(bus_wdata);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (bus_addr >= A_IV && bus_addr <= A_IV + AW'(28)) begin
        bus_rdata = iv_q[bus_addr[4:2]];
      end else begin
        case (bus_addr)
          A_CTL:  bus_rdata = {30'd0, dma_q, en_q};
          A_CFG:  bus_rdata = {26'd0, cfg_q};
          A_STAT: bus_rdata = {26'd0, st_q};
          A_SIZE: bus_rdata = {{(32-SW){1'b0}}, size_q};
          A_INT:  bus_rdata = {30'd0, ien_q, done_q};
          A_SRC:  bus_rdata = src_q;
          A_DST:  bus_rdata = dst_q;
          A_KADR: bus_rdata = kaddr_q;
          A_OUT:  bus_rdata = st_q[4] ? digest_in[(NW-1-int'(idx_q))*32 +: 32] : '0;
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  assign run_en       = en_q;
  assign dma_go       = dma_q;
  assign key_fetch    = kreq_q;
  assign last_blk     = last_q;
  assign cfg_user_iv  = cfg_q[0];
  assign cfg_no_swap  = cfg_q[1];
  assign cfg_key_src  = cfg_q[3:2];
  assign cfg_sha_only = cfg_q[4];
  assign cfg_private  = cfg_q[5];
  assign xfer_size    = size_q;
  assign block_count  = BW'({1'b0, size_q[SW-1:6]}) + BW'(1);
  assign key_addr     = kaddr_q;
  assign key_mask     = kmask_q;
  assign dma_src      = src_q;
  assign dma_dst      = dst_q;
  assign msg_push     = push_q;
  assign msg_word     = word_q;
  assign irq          = done_q & ien_q;

  AST_KEYREQ_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n) ev_key_valid |=> !key_fetch); // R3
  AST_LAST_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n) ev_hmac_ready |=> !last_blk); // R3
  AST_PUSH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_en && bus_we && bus_addr == A_IN) |=> msg_push); // R10
  AST_PUSH_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !(bus_en && bus_we && bus_addr == A_IN) |=> !msg_push); // R10
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) (ev_hmac_ready && ien_q && !(bus_en && bus_we && bus_addr == A_INT)) |=> irq); // R6
  AST_STAT_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!start && ev_vec == 6'd0) |=> (st_q[3] == $past(st_q[3]) && st_q[1:0] == $past(st_q[1:0]))); // R5
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!start && !pop) |=> $stable(idx_q)); // R11

endmodule

// File: tb/hmac_csr_test.sv
module hmac_csr_test;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [6:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic ev_hash_ready = 0, ev_msg_done = 0, ev_dma_err = 0;
  logic ev_key_valid = 0, ev_hmac_ready = 0, ev_dma_done = 0;
  logic [255:0] digest_in;
  logic run_en, dma_go, key_fetch, last_blk, cfg_user_iv, cfg_no_swap;
  logic [1:0] cfg_key_src;
  logic cfg_sha_only, cfg_private;
  logic [14:0] xfer_size;
  logic [9:0] block_count;
  logic [255:0] user_iv, key_val;
  logic [31:0] key_addr, key_mask, dma_src, dma_dst, msg_word;
  logic msg_push, irq;
  int n_chk = 0, n_fail = 0;
  bit done_run = 0;

  always #5 clk = ~clk;

  hmac_csr uut (.*);

  function automatic logic [31:0] dword(int i);
    return 32'h1000_0001 * (i + 1);
  endfunction

  initial for (int i = 0; i < 8; i++) digest_in[(7-i)*32 +: 32] = dword(i);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  task automatic pulse(logic [5:0] m);
    @(negedge clk);
    {ev_dma_done, ev_hmac_ready, ev_key_valid, ev_dma_err, ev_msg_done, ev_hash_ready} = m;
    @(negedge clk);
    {ev_dma_done, ev_hmac_ready, ev_key_valid, ev_dma_err, ev_msg_done, ev_hash_ready} = '0;
  endtask

  task automatic new_op();
    wr(7'h00, 0); wr(7'h00, 1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(7'h00, v); chk("R1 ctl", v, 0);
    rd(7'h04, v); chk("R1 cfg", v, 0);
    rd(7'h08, v); chk("R1 stat", v, 0);
    rd(7'h10, v); chk("R1 int", v, 0);
    chk("R1 irq/push", {30'd0, irq, msg_push}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(7'h00, 32'hF); rd(7'h00, v);
    chk("R2 readback", v, 3);
    chk("R2 req outs", {30'd0, key_fetch, last_blk}, 3);
  endtask

  task automatic t_selfclr();
    pulse(6'b001000); chk("R3 key_fetch clr", key_fetch, 0);
    pulse(6'b010000); chk("R3 last_blk clr", last_blk, 0);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = 0; bus_wdata = 32'h5; ev_key_valid = 1;
    @(negedge clk); bus_en = 0; bus_we = 0; ev_key_valid = 0;
    chk("R3 event wins", key_fetch, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(7'h04, 32'hFFFF_FFFF); rd(7'h04, v); chk("R4 mask", v, 32'h3F);
    wr(7'h04, 32'h19); rd(7'h04, v); chk("R4 read", v, 32'h19);
    chk("R4 fields", {26'd0, cfg_private, cfg_sha_only, cfg_key_src, cfg_no_swap, cfg_user_iv}, 32'h19);
  endtask

  task automatic t_status();
    logic [31:0] v;
    new_op();
    pulse(6'b111111); rd(7'h08, v); chk("R5 all set", v, 32'h3F);
    wr(7'h08, 32'hFFFF_FFFF); rd(7'h08, v); chk("R5 w1c", v, 32'h0B);
    new_op(); rd(7'h08, v); chk("R5 start clears", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(7'h10, 2); pulse(6'b010000);
    chk("R6 irq set", irq, 1);
    wr(7'h10, 2); rd(7'h10, v); chk("R6 write0 noeffect", v, 3);
    wr(7'h10, 3); rd(7'h10, v); chk("R6 w1c", v, 2); chk("R6 irq low", irq, 0);
    pulse(6'b010000); wr(7'h10, 0);
    rd(7'h10, v); chk("R6 gated", {v[30:0], irq}, 2);
  endtask

  task automatic t_size();
    logic [31:0] v;
    wr(7'h0C, 32'hFFFF_FFFF); rd(7'h0C, v); chk("R7 15 bits", v, 32'h7FFF);
    chk("R7 512", block_count, 512);
    wr(7'h0C, 32'h3F); chk("R7 1 blk", block_count, 1);
    wr(7'h0C, 32'h7F); chk("R7 2 blk", block_count, 2);
  endtask

  task automatic t_iv();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) wr(7'(32 + 4*i), 32'hA000_0000 + i);
    for (int i = 0; i < 8; i++) begin rd(7'(32 + 4*i), v); chk("R8 readback", v, 32'hA000_0000 + i); end
    chk("R8 top word", user_iv[255:224], 32'hA000_0000);
    chk("R8 low word", user_iv[31:0], 32'hA000_0007);
  endtask

  task automatic t_key();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) wr(7'(72 + 4*i), 32'hC000_0000 + i);
    rd(7'h48, v); chk("R9 key wo", v, 0);
    chk("R9 key map", key_val[255:224], 32'hC000_0000);
    chk("R9 key low", key_val[31:0], 32'hC000_0007);
    wr(7'h6C, 32'h1234_5678); rd(7'h6C, v); chk("R9 mask wo", v, 0);
    chk("R9 mask out", key_mask, 32'h1234_5678);
    wr(7'h68, 32'hBEEF_0004); rd(7'h68, v); chk("R9 kaddr", v, 32'hBEEF_0004);
  endtask

  task automatic t_msg();
    logic [31:0] v;
    wr(7'h04, 0); wr(7'h44, 32'h1122_3344);
    chk("R10 push", msg_push, 1); chk("R10 swapped", msg_word, 32'h4433_2211);
    @(negedge clk); chk("R10 one cycle", msg_push, 0);
    wr(7'h04, 2); wr(7'h44, 32'h1122_3344);
    chk("R10 no swap", msg_word, 32'h1122_3344);
    rd(7'h44, v); chk("R10 read zero", v, 0);
  endtask

  task automatic t_out();
    logic [31:0] v;
    new_op();
    rd(7'h40, v); chk("R11 not ready", v, 0);
    pulse(6'b010000);
    for (int i = 0; i < 9; i++) begin rd(7'h40, v); chk("R11 word", v, dword(i % 8)); end
    rd(7'h40, v); rd(7'h40, v);
    new_op(); pulse(6'b010000);
    rd(7'h40, v); chk("R11 idx reset", v, dword(0));
  endtask

  task automatic t_dma();
    logic [31:0] v;
    wr(7'h14, 32'h8000_0010); wr(7'h18, 32'h9000_0020);
    rd(7'h14, v); chk("R12 src", v, 32'h8000_0010);
    rd(7'h18, v); chk("R12 dst", v, 32'h9000_0020);
    rd(7'h1C, v); chk("R12 unmapped", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_ctrl(); t_selfclr(); t_cfg(); t_status(); t_irq();
    t_size(); t_iv(); t_key(); t_msg(); t_out(); t_dma();
    done_run = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule